// File: doc/BRIEF.md
# Tag-Renaming Reservation Station

This block renames register destinations and schedules instructions whose operands arrive out of order. Each architectural register holds a ready bit, a pending tag and a value. A FIFO of free tags supplies a fresh destination tag to every instruction that enters. Up to two instructions enter per cycle. Each one copies either a finished value or a pending tag for each of its two sources into a station entry. When both sources of an entry are ready and the function unit reports that it is free, the entry is sent out and leaves the station.

A result bus carries a tag and a value. Every waiting source that holds that tag captures the value. The architectural register takes the value only if it still waits on exactly that tag, so a result from an older producer cannot overwrite the claim of a newer one. The tag then returns to the back of the free FIFO. A peek port shows any register's state for observation.

Top module: `tag_rename_station`

## Requirements
- R1: After reset, every register is ready and holds its own index as its value. The station is empty. The free FIFO holds all tags, in increasing order from tag 0.
- R2: The request count is the number of valid slots among slot 0 and slot 1. `disp_accept` is high when that count is no more than the free tags and no more than the free station entries. When it is low, neither slot enters, no tag is taken and no register changes.
- R3: Accepted instructions take tags from the head of the free FIFO. Slot 0 takes its tag before slot 1.
- R4: A source whose register is ready takes that register's value. A source whose register is pending takes the register's tag and is not ready. If that pending tag is on the result bus in the same cycle, the source takes the bus value and is ready.
- R5: When both slots enter together and a source of slot 1 names slot 0's destination, that source takes slot 0's new tag and is not ready.
- R6: An accepted instruction marks its destination register not ready and writes its new tag there. When both slots name the same destination, the register ends up holding slot 1's tag.
- R7: `iss_valid` shows whether any entry has both sources ready, and the issue outputs then present the oldest such entry. When `fu_free` is also high, that entry leaves the station at the clock edge.
- R8: A result broadcast makes every waiting station source with the matching tag ready, carrying the broadcast value, from the next cycle onward.
- R9: A broadcast writes a register only when that register is pending on the broadcast tag. That register is then ready with the value from the next cycle. A broadcast of any other tag leaves the register unchanged.
- R10: Each broadcast tag joins the back of the free FIFO. It is handed out again only after the tags already queued ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d0_valid | input | 1 | Slot 0 instruction present |
| d0_op | input | 4 | Slot 0 opcode |
| d0_dst | input | 3 | Slot 0 destination register |
| d0_src_a | input | 3 | Slot 0 first source register |
| d0_src_b | input | 3 | Slot 0 second source register |
| d1_valid | input | 1 | Slot 1 instruction present |
| d1_op | input | 4 | Slot 1 opcode |
| d1_dst | input | 3 | Slot 1 destination register |
| d1_src_a | input | 3 | Slot 1 first source register |
| d1_src_b | input | 3 | Slot 1 second source register |
| disp_accept | output | 1 | Valid slots are taken this cycle |
| fu_free | input | 1 | Function unit can take an entry |
| iss_valid | output | 1 | A ready entry is presented |
| iss_op | output | 4 | Opcode of presented entry |
| iss_tag | output | 3 | Destination tag of presented entry |
| iss_opnd_a | output | 16 | First operand value |
| iss_opnd_b | output | 16 | Second operand value |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | 3 | Tag of broadcast result |
| res_value | input | 16 | Value of broadcast result |
| peek_idx | input | 3 | Register to observe |
| peek_ready | output | 1 | Observed register is ready |
| peek_tag | output | 3 | Observed register's pending tag |
| peek_value | output | 16 | Observed register's value |

## Verification
The assertions assume that a broadcast names only a tag that is outstanding: handed out, not yet returned, and broadcast once. Under that assumption the free FIFO can never overflow, and a waiting register always finds its producer. The stimulus broadcasts only tags whose allocation order it has tracked, and it sends each tag once between resets. It never broadcasts a tag that is still sitting in the free FIFO.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int NUM_TAGS = 8;
    localparam int RS_DEPTH = 4;
    localparam int OP_W     = 4;

    localparam int REG_W = $clog2(NUM_REGS);
    localparam int TAG_W = $clog2(NUM_TAGS);
    localparam int CNT_W = $clog2(NUM_TAGS + 1);
    localparam int OCC_W = $clog2(RS_DEPTH + 1);
    localparam int IDX_W = $clog2(RS_DEPTH);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef struct packed {
        logic  ready;
        tag_t  tag;
        word_t value;
    } operand_t;

    typedef struct packed {
        logic     valid;
        op_t      op;
        tag_t     dtag;
        operand_t a;
        operand_t b;
    } rs_entry_t;

    // Capture a broadcast into a waiting operand.
    function automatic operand_t snoop(operand_t o, logic bv, tag_t bt, word_t bval);
        operand_t r;
        r = o;
        if (!o.ready && bv && (o.tag == bt)) begin
            r.ready = 1'b1;
            r.value = bval;
        end
        return r;
    endfunction

endpackage

// File: rtl/rsu_tag_pool.sv
module rsu_tag_pool
    import rsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pop_n,
    input  logic             push,
    input  tag_t             push_tag,
    output tag_t             head0,
    output tag_t             head1,
    output logic [CNT_W-1:0] avail
);
    tag_t             fifo_q [NUM_TAGS];
    tag_t             rd_q;
    tag_t             wr_q;
    logic [CNT_W-1:0] count_q;

    assign head0 = fifo_q[rd_q];
    assign head1 = fifo_q[rd_q + tag_t'(1)];
    assign avail = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_TAGS; i++) fifo_q[i] <= tag_t'(i);
            rd_q    <= '0;
            wr_q    <= '0;
            count_q <= CNT_W'(NUM_TAGS);
        end else begin
            if (push) begin
                fifo_q[wr_q] <= push_tag;
                wr_q         <= wr_q + tag_t'(1);
            end
            rd_q    <= rd_q + tag_t'(pop_n);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop_n);
        end
    end

    p_pop_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (pop_n != 2'd0) |-> (CNT_W'(pop_n) <= count_q));

    p_pool_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> ((count_q < CNT_W'(NUM_TAGS)) || (pop_n != 2'd0)));

endmodule

// File: rtl/rsu_regfile.sv
module rsu_regfile
    import rsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr0_en,
    input  reg_idx_t wr0_idx,
    input  tag_t     wr0_tag,
    input  logic     wr1_en,
    input  reg_idx_t wr1_idx,
    input  tag_t     wr1_tag,
    input  logic     bc_valid,
    input  tag_t     bc_tag,
    input  word_t    bc_value,
    input  reg_idx_t rd_idx  [4],
    output operand_t rd_data [4],
    input  reg_idx_t peek_idx,
    output operand_t peek_data
);
    operand_t regs_q [NUM_REGS];
    operand_t regs_d [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (bc_valid && !regs_q[i].ready && (regs_q[i].tag == bc_tag)) begin
                regs_d[i].ready = 1'b1;
                regs_d[i].value = bc_value;
            end
            if (wr0_en && (wr0_idx == reg_idx_t'(i))) begin
                regs_d[i].ready = 1'b0;
                regs_d[i].tag   = wr0_tag;
            end
            if (wr1_en && (wr1_idx == reg_idx_t'(i))) begin
                regs_d[i].ready = 1'b0;
                regs_d[i].tag   = wr1_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= '{ready: 1'b1, tag: '0, value: word_t'(i)};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < 4; p++) begin : g_rd
        assign rd_data[p] = regs_q[rd_idx[p]];
    end

    assign peek_data = regs_q[peek_idx];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        logic untouched;
        assign untouched = !(wr0_en && (wr0_idx == reg_idx_t'(g)))
                        && !(wr1_en && (wr1_idx == reg_idx_t'(g)));

        p_wb_match_r9: assert property (@(posedge clk) disable iff (rst)
            (bc_valid && !regs_q[g].ready && (regs_q[g].tag == bc_tag) && untouched)
            |=> (regs_q[g].ready && (regs_q[g].value == $past(bc_value))));

        p_wb_stale_r9: assert property (@(posedge clk) disable iff (rst)
            (bc_valid && (regs_q[g].tag != bc_tag) && untouched)
            |=> (regs_q[g] == $past(regs_q[g])));
    end

endmodule

// File: rtl/rsu_station.sv
module rsu_station
    import rsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rs_entry_t        new0,
    input  rs_entry_t        new1,
    input  logic             fu_free,
    input  logic             bc_valid,
    input  tag_t             bc_tag,
    input  word_t            bc_value,
    output logic             iss_valid,
    output rs_entry_t        iss_entry,
    output logic [OCC_W-1:0] free_slots
);
    rs_entry_t        q_q [RS_DEPTH];
    rs_entry_t        q_d [RS_DEPTH];
    rs_entry_t        woken [RS_DEPTH];
    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] occ_d;
    logic [OCC_W-1:0] push_n;
    logic [IDX_W-1:0] iss_idx;
    logic             fire;

    // Lowest index is oldest: pick the first fully ready entry.
    always_comb begin
        iss_valid = 1'b0;
        iss_idx   = '0;
        for (int i = RS_DEPTH - 1; i >= 0; i--) begin
            if (q_q[i].valid && q_q[i].a.ready && q_q[i].b.ready) begin
                iss_valid = 1'b1;
                iss_idx   = IDX_W'(i);
            end
        end
    end

    assign iss_entry  = q_q[iss_idx];
    assign fire       = iss_valid && fu_free;
    assign free_slots = OCC_W'(RS_DEPTH) - occ_q;
    assign push_n     = OCC_W'(new0.valid) + OCC_W'(new1.valid);

    always_comb begin
        logic [OCC_W-1:0] n;
        int               src;
        for (int i = 0; i < RS_DEPTH; i++) begin
            woken[i]   = q_q[i];
            woken[i].a = snoop(q_q[i].a, bc_valid, bc_tag, bc_value);
            woken[i].b = snoop(q_q[i].b, bc_valid, bc_tag, bc_value);
        end
        for (int i = 0; i < RS_DEPTH; i++) begin
            src = i + ((fire && (i >= int'(iss_idx))) ? 1 : 0);
            q_d[i] = (src < RS_DEPTH) ? woken[IDX_W'(src)] : '0;
        end
        n = occ_q - OCC_W'(fire);
        if (new0.valid && (n < OCC_W'(RS_DEPTH))) begin
            q_d[IDX_W'(n)] = new0;
            n = n + OCC_W'(1);
        end
        if (new1.valid && (n < OCC_W'(RS_DEPTH))) begin
            q_d[IDX_W'(n)] = new1;
        end
        occ_d = occ_q - OCC_W'(fire) + push_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RS_DEPTH; i++) q_q[i] <= '0;
            occ_q <= '0;
        end else begin
            q_q   <= q_d;
            occ_q <= occ_d;
        end
    end

    p_issue_retire_r7: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && fu_free) |=> ((occ_q + OCC_W'(1)) == ($past(occ_q) + $past(push_n))));

    p_push_fits_r2: assert property (@(posedge clk) disable iff (rst)
        (push_n != '0) |-> (push_n <= free_slots));

endmodule

// File: rtl/tag_rename_station.sv
module tag_rename_station
    import rsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              d0_valid,
    input  logic [OP_W-1:0]   d0_op,
    input  logic [REG_W-1:0]  d0_dst,
    input  logic [REG_W-1:0]  d0_src_a,
    input  logic [REG_W-1:0]  d0_src_b,
    input  logic              d1_valid,
    input  logic [OP_W-1:0]   d1_op,
    input  logic [REG_W-1:0]  d1_dst,
    input  logic [REG_W-1:0]  d1_src_a,
    input  logic [REG_W-1:0]  d1_src_b,
    output logic              disp_accept,
    input  logic              fu_free,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [DATA_W-1:0] iss_opnd_a,
    output logic [DATA_W-1:0] iss_opnd_b,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic [REG_W-1:0]  peek_idx,
    output logic              peek_ready,
    output logic [TAG_W-1:0]  peek_tag,
    output logic [DATA_W-1:0] peek_value
);
    logic [1:0]       need;
    logic [1:0]       pop_n;
    logic             acc0;
    logic             acc1;
    logic [CNT_W-1:0] avail;
    logic [OCC_W-1:0] free_slots;
    tag_t             head0;
    tag_t             head1;
    tag_t             tag0;
    tag_t             tag1;
    reg_idx_t         rd_idx [4];
    operand_t         rd_data [4];
    operand_t         peek_data;
    operand_t         opa0, opb0, opa1, opb1;
    rs_entry_t        new0, new1, iss_entry;

    assign need        = {1'b0, d0_valid} + {1'b0, d1_valid};
    assign disp_accept = (CNT_W'(need) <= avail) && (OCC_W'(need) <= free_slots);
    assign acc0        = d0_valid && disp_accept;
    assign acc1        = d1_valid && disp_accept;
    assign pop_n       = {1'b0, acc0} + {1'b0, acc1};
    assign tag0        = head0;
    assign tag1        = acc0 ? head1 : head0;

    assign rd_idx[0] = d0_src_a;
    assign rd_idx[1] = d0_src_b;
    assign rd_idx[2] = d1_src_a;
    assign rd_idx[3] = d1_src_b;

    rsu_tag_pool u_pool (
        .clk      (clk),
        .rst      (rst),
        .pop_n    (pop_n),
        .push     (res_valid),
        .push_tag (res_tag),
        .head0    (head0),
        .head1    (head1),
        .avail    (avail)
    );

    rsu_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr0_en    (acc0),
        .wr0_idx   (d0_dst),
        .wr0_tag   (tag0),
        .wr1_en    (acc1),
        .wr1_idx   (d1_dst),
        .wr1_tag   (tag1),
        .bc_valid  (res_valid),
        .bc_tag    (res_tag),
        .bc_value  (res_value),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    // Source capture, with same-cycle broadcast bypass and pair forwarding.
    always_comb begin
        opa0 = snoop(rd_data[0], res_valid, res_tag, res_value);
        opb0 = snoop(rd_data[1], res_valid, res_tag, res_value);
        opa1 = snoop(rd_data[2], res_valid, res_tag, res_value);
        opb1 = snoop(rd_data[3], res_valid, res_tag, res_value);
        if (acc0 && (d1_src_a == d0_dst)) opa1 = '{ready: 1'b0, tag: tag0, value: '0};
        if (acc0 && (d1_src_b == d0_dst)) opb1 = '{ready: 1'b0, tag: tag0, value: '0};
    end

    assign new0 = '{valid: acc0, op: d0_op, dtag: tag0, a: opa0, b: opb0};
    assign new1 = '{valid: acc1, op: d1_op, dtag: tag1, a: opa1, b: opb1};

    rsu_station u_rs (
        .clk        (clk),
        .rst        (rst),
        .new0       (new0),
        .new1       (new1),
        .fu_free    (fu_free),
        .bc_valid   (res_valid),
        .bc_tag     (res_tag),
        .bc_value   (res_value),
        .iss_valid  (iss_valid),
        .iss_entry  (iss_entry),
        .free_slots (free_slots)
    );

    assign iss_op     = iss_entry.op;
    assign iss_tag    = iss_entry.dtag;
    assign iss_opnd_a = iss_entry.a.value;
    assign iss_opnd_b = iss_entry.b.value;
    assign peek_ready = peek_data.ready;
    assign peek_tag   = peek_data.tag;
    assign peek_value = peek_data.value;

    p_stall_keeps_pool_r2: assert property (@(posedge clk) disable iff (rst)
        (!(disp_accept && (d0_valid || d1_valid)) && !res_valid) |=> (avail == $past(avail)));

endmodule

// File: tb/tag_rename_station_test.sv
module tag_rename_station_test;
    import rsu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              d0_valid, d1_valid, fu_free, res_valid;
    logic [OP_W-1:0]   d0_op, d1_op;
    logic [REG_W-1:0]  d0_dst, d0_src_a, d0_src_b, d1_dst, d1_src_a, d1_src_b, peek_idx;
    logic [TAG_W-1:0]  res_tag;
    logic [DATA_W-1:0] res_value;
    logic              disp_accept, iss_valid, peek_ready;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_tag, peek_tag;
    logic [DATA_W-1:0] iss_opnd_a, iss_opnd_b, peek_value;

    int n_chk  = 0;
    int n_fail = 0;

    tag_rename_station uut (
        .clk(clk), .rst(rst),
        .d0_valid(d0_valid), .d0_op(d0_op), .d0_dst(d0_dst), .d0_src_a(d0_src_a), .d0_src_b(d0_src_b),
        .d1_valid(d1_valid), .d1_op(d1_op), .d1_dst(d1_dst), .d1_src_a(d1_src_a), .d1_src_b(d1_src_b),
        .disp_accept(disp_accept), .fu_free(fu_free),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_tag(iss_tag),
        .iss_opnd_a(iss_opnd_a), .iss_opnd_b(iss_opnd_b),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .peek_idx(peek_idx), .peek_ready(peek_ready), .peek_tag(peek_tag), .peek_value(peek_value)
    );

    typedef struct packed {
        logic d0v; logic [2:0] d0d; logic [2:0] d0a; logic [2:0] d0b;
        logic d1v; logic [2:0] d1d; logic [2:0] d1a; logic [2:0] d1b;
        logic fu; logic cv; logic [2:0] ct; logic [15:0] cval; logic [2:0] pk;
        logic e_acc; logic e_iv; logic [3:0] e_op; logic [2:0] e_tag;
        logic [15:0] e_a; logic [15:0] e_b;
        logic e_rdy; logic [2:0] e_ptag; logic [15:0] e_pval;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{0,0,0,0, 0,0,0,0, 0, 0,0,0,   3, 1, 0,0,0,0,0,     1,0,3},
        '{1,1,2,3, 1,4,1,5, 0, 0,0,0,   1, 1, 0,0,0,0,0,     1,0,1},
        '{0,0,0,0, 0,0,0,0, 1, 0,0,0,   1, 1, 1,1,0,2,3,     0,0,0},
        '{0,0,0,0, 0,0,0,0, 1, 1,0,100, 1, 1, 0,0,0,0,0,     0,0,0},
        '{0,0,0,0, 0,0,0,0, 0, 0,0,0,   1, 1, 1,2,1,100,5,   1,0,100},
        '{1,6,4,4, 0,0,0,0, 1, 0,0,0,   6, 1, 1,2,1,100,5,   1,0,6},
        '{1,7,4,6, 0,0,0,0, 1, 1,1,7,   4, 1, 0,0,0,0,0,     0,1,0},
        '{0,0,0,0, 0,0,0,0, 1, 0,0,0,   4, 1, 1,1,2,7,7,     1,0,7},
        '{0,0,0,0, 0,0,0,0, 1, 1,2,9,   6, 1, 0,0,0,0,0,     0,2,0},
        '{0,0,0,0, 0,0,0,0, 1, 0,0,0,   6, 1, 1,1,3,7,9,     1,0,9}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic idle();
        d0_valid = 0; d0_op = 4'd1; d0_dst = 0; d0_src_a = 0; d0_src_b = 0;
        d1_valid = 0; d1_op = 4'd2; d1_dst = 0; d1_src_a = 0; d1_src_b = 0;
        fu_free = 0; res_valid = 0; res_tag = 0; res_value = 0; peek_idx = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        for (int i = 0; i < NUM_REGS; i++) begin
            peek_idx = REG_W'(i);
            #1;
            check("R1 reg ready", peek_ready, 1);
            check("R1 reg value", peek_value, i);
        end
        check("R1 station empty", iss_valid, 0);
        idle();

        // Table walk: R3 R4 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            d0_valid = VT[v].d0v; d0_dst = VT[v].d0d; d0_src_a = VT[v].d0a; d0_src_b = VT[v].d0b;
            d1_valid = VT[v].d1v; d1_dst = VT[v].d1d; d1_src_a = VT[v].d1a; d1_src_b = VT[v].d1b;
            fu_free = VT[v].fu; res_valid = VT[v].cv; res_tag = VT[v].ct; res_value = VT[v].cval;
            peek_idx = VT[v].pk;
            #1;
            check("R2 accept", disp_accept, VT[v].e_acc);
            check("R7 iss_valid", iss_valid, VT[v].e_iv);
            if (VT[v].e_iv) begin
                check("R7 iss_op", iss_op, VT[v].e_op);
                check("R3 iss_tag", iss_tag, VT[v].e_tag);
                check("R4 R8 opnd_a", iss_opnd_a, VT[v].e_a);
                check("R4 R8 opnd_b", iss_opnd_b, VT[v].e_b);
            end
            check("R9 peek_ready", peek_ready, VT[v].e_rdy);
            if (VT[v].e_rdy) check("R9 peek_value", peek_value, VT[v].e_pval);
            else             check("R6 peek_tag", peek_tag, VT[v].e_ptag);
            tick();
        end

        // R6 same destination in a pair, R9 stale broadcast, R7 oldest first
        do_reset();
        d0_valid = 1; d0_dst = 1; d0_src_a = 2; d0_src_b = 3;
        d1_valid = 1; d1_dst = 1; d1_src_a = 2; d1_src_b = 3;
        tick();
        idle();
        peek_idx = 1;
        #1;
        check("R6 pair dst not ready", peek_ready, 0);
        check("R6 pair dst tag", peek_tag, 1);
        res_valid = 1; res_tag = 0; res_value = 55;
        tick();
        res_valid = 0;
        #1;
        check("R9 stale ignored ready", peek_ready, 0);
        check("R9 stale ignored tag", peek_tag, 1);
        res_valid = 1; res_tag = 1; res_value = 66;
        tick();
        res_valid = 0;
        #1;
        check("R9 match ready", peek_ready, 1);
        check("R9 match value", peek_value, 66);
        fu_free = 1;
        #1;
        check("R7 oldest tag", iss_tag, 0);
        check("R7 oldest op", iss_op, 1);
        tick();
        check("R7 next tag", iss_tag, 1);
        check("R7 next op", iss_op, 2);
        tick();
        check("R7 removed", iss_valid, 0);

        // R5 pair forwarding
        do_reset();
        d0_valid = 1; d0_dst = 3; d0_src_a = 1; d0_src_b = 2;
        d1_valid = 1; d1_dst = 4; d1_src_a = 3; d1_src_b = 3;
        tick();
        idle();
        fu_free = 1;
        #1;
        check("R5 producer issues", iss_tag, 0);
        tick();
        check("R5 consumer waits", iss_valid, 0);
        res_valid = 1; res_tag = 0; res_value = 40;
        tick();
        res_valid = 0;
        #1;
        check("R5 consumer ready", iss_valid, 1);
        check("R5 consumer tag", iss_tag, 1);
        check("R5 consumer a", iss_opnd_a, 40);
        check("R5 consumer b", iss_opnd_b, 40);

        // R2 full station
        do_reset();
        d0_valid = 1; d0_dst = 5; d1_valid = 1; d1_dst = 6;
        tick();
        tick();
        d0_dst = 7; d1_dst = 7; peek_idx = 7;
        #1;
        check("R2 full pair stalls", disp_accept, 0);
        tick();
        check("R2 stall leaves reg ready", peek_ready, 1);
        check("R2 stall leaves reg value", peek_value, 7);
        d1_valid = 0;
        #1;
        check("R2 full single stalls", disp_accept, 0);
        fu_free = 1;
        tick();
        fu_free = 0;
        d1_valid = 1;
        #1;
        check("R2 one slot pair stalls", disp_accept, 0);
        d1_valid = 0;
        #1;
        check("R2 one slot single accepted", disp_accept, 1);
        tick();
        idle();
        peek_idx = 7;
        #1;
        check("R3 next tag in order", peek_tag, 4);

        // R2 empty pool, R3 order, R10 recycle
        do_reset();
        fu_free = 1;
        d0_valid = 1; d0_dst = 1;
        for (int k = 0; k < NUM_TAGS; k++) begin
            #1;
            check("R2 pool accept", disp_accept, 1);
            if (k > 0) check("R3 tag order", iss_tag, k - 1);
            tick();
        end
        res_valid = 1; res_tag = 5; res_value = 0;
        #1;
        check("R2 pool empty stalls", disp_accept, 0);
        tick();
        res_valid = 0;
        #1;
        check("R10 recycled accept", disp_accept, 1);
        tick();
        idle();
        peek_idx = 1;
        #1;
        check("R10 recycled tag", peek_tag, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule